// File: doc/BRIEF.md
# Dual-Channel Timer Register Bank

This block is the software-visible register file for a pair of timer channels. A simple register bus reads and writes 32-bit words at fixed offsets. For each channel the bank holds a control/status word, a load register and a read-only view of the live count. The counters sit outside the bank. The bank gives each channel its control fields and its load value. From each channel it takes an interrupt event pulse, a captured value with its write strobe, and the running count.

An enable-all bit is shared by both control words. Writing 1 to it starts both channels in the same cycle. Each channel has an interrupt flag. The flag is set by that channel's event, stays set, and clears only when software writes 1 to it. A per-channel interrupt enable gates the flag onto one combined interrupt line.

A load value or count narrower than 32 bits is right-justified, and the unused upper bits read as zero. A bus read of a load register sends a one-cycle pulse to the matching channel. A channel in capture-hold can use this pulse to accept a new capture.

Top module: `tmr_regbank`

## Requirements
- R1: Address bits [4:2] select the register: ctl0=0x00, load0=0x04, count0=0x08, ctl1=0x10, load1=0x14, count1=0x18. The offsets 0x0C and 0x1C, and any address with a bit above bit 4 set, read as zero. Writes to count offsets change nothing.
- R2: Control word bit positions: 0 capture mode, 1 count down, 2 generate-out enable, 3 capture enable, 4 auto-reload, 5 load, 6 interrupt enable, 7 timer enable, 8 interrupt flag, 9 PWM enable, 10 enable-all. Bits 31:11 read zero. Every bit resets to 0. Output `ch_ctl[c]` carries bits 10:0 of channel c.
- R3: A control write with byte lane 1 enabled and wdata[10]=1 sets enable-all and the timer enable (bit 7) of both channels on the next edge.
- R4: A control write with byte lane 1 enabled and wdata[10]=0 clears enable-all and leaves both timer enables unchanged.
- R5: An event pulse sets the channel's flag. A control write with lane 1 enabled and wdata[8]=1 clears it. Writing 0 to bit 8 has no effect.
- R6: An event in the same cycle as a write-1 clear leaves the flag set.
- R7: `irq` is the OR over channels of (flag AND interrupt enable). The enable never changes the flag.
- R8: Load and count values are CNT_W bits wide, right-justified with the LSB at bit 0. Load writes follow byte enables: lane b covers bits 8b+7..8b. Control bits 7:0 are in lane 0, and bits 10:8 are in lane 1.
- R9: Each read or write strobe is acknowledged by `bus_ack` for exactly one cycle on the following cycle. Read data is valid with that acknowledge and is zero otherwise.
- R10: A read of load register c pulses `ch_load_rd[c]` in the same cycle as its acknowledge.
- R11: A capture strobe writes its value into the load register. When it coincides with a bus write to the same load register, the capture value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables for writes |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 32 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle acknowledge |
| ch_event | input | 2 | Per-channel interrupt event pulse |
| ch_cap_we | input | 2 | Per-channel capture write strobe |
| ch_cap_val | input | 2×CNT_W | Per-channel captured value |
| ch_count | input | 2×CNT_W | Per-channel live count |
| ch_ctl | output | 2×11 | Per-channel control fields, bits 10:0 |
| ch_load | output | 2×CNT_W | Per-channel load register |
| ch_load_rd | output | 2 | Pulse on a bus read of the load register |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with CNT_W=12 and ADDR_W=5. With a width of 12, byte lane 1 covers only part of the counter, so a masked byte write has to truncate inside that lane. Lanes 2 and 3 must then read back as zero. Comparing against a behavioural model on every cycle exposes ordering mistakes where strobes coincide: event against clear, capture against bus write, and enable-all set against a zero written to a timer enable bit.

// File: rtl/tmr_regbank_pkg.sv
package tmr_regbank_pkg;
  localparam int BUS_W   = 32;
  localparam int BE_W    = BUS_W / 8;
  localparam int CTL_W   = 11;
  localparam int B_MODE  = 0;
  localparam int B_DOWN  = 1;
  localparam int B_GEN   = 2;
  localparam int B_CAP   = 3;
  localparam int B_AUTO  = 4;
  localparam int B_LOAD  = 5;
  localparam int B_IE    = 6;
  localparam int B_TEN   = 7;
  localparam int B_FLAG  = 8;
  localparam int B_PWM   = 9;
  localparam int B_ENALL = 10;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // byte-lane merge of a write into an old word
  function automatic logic [BUS_W-1:0] lane_merge(input logic [BUS_W-1:0] old_w,
                                                   input logic [BUS_W-1:0] new_w,
                                                   input logic [BE_W-1:0]  be);
    logic [BUS_W-1:0] r;
    for (int i = 0; i < BUS_W; i++) r[i] = be[i/8] ? new_w[i] : old_w[i];
    return r;
  endfunction
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_regbank_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ch,
  output reg_sel_e          sel
);
  logic hi_zero;
  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  generate
    if (ADDR_W > 5) begin : g_hi
      assign hi_zero = ~|addr[ADDR_W-1:5];
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  assign ch  = addr[4];
  assign sel = hi_zero ? reg_sel_e'(addr[3:2]) : SEL_NONE;
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_regbank_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctl,
  input  logic             wr_load,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BE_W-1:0]  be,
  input  logic             set_en,
  input  logic             ev,
  input  logic             cap_we,
  input  logic [CNT_W-1:0] cap_val,
  output logic [9:0]       ctl_q,
  output logic [CNT_W-1:0] load_q
);
  logic [9:0]       ctl_d;
  logic [CNT_W-1:0] load_d;
  logic             flag_clr;
  logic             flag_set;
  logic [BUS_W-1:0] old32;
  logic [BUS_W-1:0] mrg32;
  logic             unused_hi;

  assign unused_hi = ^{wdata[BUS_W-1:11], wdata[10], mrg32};
  assign flag_clr  = wr_ctl && be[1] && wdata[B_FLAG];
  assign flag_set  = ev;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl && be[0]) ctl_d[7:0] = wdata[7:0];
    if (wr_ctl && be[1]) ctl_d[B_PWM] = wdata[B_PWM];
    if (set_en)          ctl_d[B_TEN] = 1'b1;
    if (flag_set)        ctl_d[B_FLAG] = 1'b1;
    else if (flag_clr)   ctl_d[B_FLAG] = 1'b0;
  end

  always_comb begin
    old32 = '0;
    old32[CNT_W-1:0] = load_q;
    mrg32 = lane_merge(old32, wdata, be);
    load_d = load_q;
    if (cap_we)       load_d = cap_val;
    else if (wr_load) load_d = mrg32[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      load_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      load_q <= load_d;
    end
  end

  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> ctl_q[B_FLAG]);
  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !ev) |=> !ctl_q[B_FLAG]);
  p_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && be[1] && !wdata[B_FLAG] && !ev) |=> $stable(ctl_q[B_FLAG]));
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && ev) |=> ctl_q[B_FLAG]);
  p_enall_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ctl_q[B_TEN]);
  p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cap_we |=> (load_q == $past(cap_val)));
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_regbank_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  input  logic [3:0]                 bus_be,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  output logic [31:0]                bus_rdata,
  output logic                       bus_ack,
  input  logic [1:0]                 ch_event,
  input  logic [1:0]                 ch_cap_we,
  input  logic [1:0][CNT_W-1:0]      ch_cap_val,
  input  logic [1:0][CNT_W-1:0]      ch_count,
  output logic [1:0][10:0]           ch_ctl,
  output logic [1:0][CNT_W-1:0]      ch_load,
  output logic [1:0]                 ch_load_rd,
  output logic                       irq
);
  localparam int NCH = 2;

  logic           dec_ch;
  reg_sel_e       dec_sel;
  logic           enall_q;
  logic           ctl_wr_any;
  logic           enall_set;
  logic [NCH-1:0] wr_ctl;
  logic [NCH-1:0] wr_load;
  logic [NCH-1:0] irq_ch;
  logic [NCH-1:0][9:0] ctl_vec;
  logic [NCH-1:0][BUS_W-1:0] load32;
  logic [NCH-1:0][BUS_W-1:0] cnt32;
  logic [BUS_W-1:0] rd_word;

  tmr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .ch   (dec_ch),
    .sel  (dec_sel)
  );

  assign ctl_wr_any = bus_wr && (dec_sel == SEL_CTL);
  assign enall_set  = ctl_wr_any && bus_be[1] && bus_wdata[B_ENALL];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign wr_ctl[c]  = ctl_wr_any && (dec_ch == c[0]);
      assign wr_load[c] = bus_wr && (dec_sel == SEL_LOAD) && (dec_ch == c[0]);

      tmr_chan_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctl  (wr_ctl[c]),
        .wr_load (wr_load[c]),
        .wdata   (bus_wdata),
        .be      (bus_be),
        .set_en  (enall_set),
        .ev      (ch_event[c]),
        .cap_we  (ch_cap_we[c]),
        .cap_val (ch_cap_val[c]),
        .ctl_q   (ctl_vec[c]),
        .load_q  (ch_load[c])
      );

      assign ch_ctl[c] = {enall_q, ctl_vec[c]};
      assign irq_ch[c] = ctl_vec[c][B_FLAG] && ctl_vec[c][B_IE];

      always_comb begin
        load32[c] = '0;
        load32[c][CNT_W-1:0] = ch_load[c];
        cnt32[c] = '0;
        cnt32[c][CNT_W-1:0] = ch_count[c];
      end
    end
  endgenerate

  assign irq = |irq_ch;

  always_comb begin
    rd_word = '0;
    case (dec_sel)
      SEL_CTL:  rd_word[CTL_W-1:0] = ch_ctl[dec_ch];
      SEL_LOAD: rd_word = load32[dec_ch];
      SEL_CNT:  rd_word = cnt32[dec_ch];
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enall_q    <= 1'b0;
      bus_ack    <= 1'b0;
      bus_rdata  <= '0;
      ch_load_rd <= '0;
    end else begin
      if (ctl_wr_any && bus_be[1]) enall_q <= bus_wdata[B_ENALL];
      bus_ack    <= bus_wr || bus_rd;
      bus_rdata  <= bus_rd ? rd_word : '0;
      ch_load_rd <= '0;
      if (bus_rd && dec_sel == SEL_LOAD) ch_load_rd[dec_ch] <= 1'b1;
    end
  end

  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) |=> bus_ack);
  p_no_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> !bus_ack);
  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && dec_sel == SEL_NONE) |=> (bus_rdata == '0));
  p_load_rd_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_load_rd) |-> (bus_ack && $onehot0(ch_load_rd)));
  p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_ctl[0][B_IE] && !ch_ctl[1][B_IE]) |-> !irq);
  p_enall_both_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enall_set |=> (ch_ctl[0][B_TEN] && ch_ctl[1][B_TEN] && ch_ctl[0][B_ENALL]));
endmodule

// File: tb/test_tmr_regbank.sv
`timescale 1ns/1ps
module test_tmr_regbank;
  localparam int CW = 12;
  localparam int AW = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0] bus_be = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_rdata;
  logic bus_ack;
  logic [1:0] ch_event = '0, ch_cap_we = '0;
  logic [1:0][CW-1:0] ch_cap_val = '0, ch_count = '0;
  logic [1:0][10:0] ch_ctl;
  logic [1:0][CW-1:0] ch_load;
  logic [1:0] ch_load_rd;
  logic irq;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [10:0] m_ctl [2];
  logic [CW-1:0] m_load [2];
  logic m_enall = 0, m_ack = 0;
  logic [31:0] m_rdata = '0;
  logic [1:0] m_lrd = '0;

  always #2.5 clk = ~clk;

  tmr_regbank #(.CNT_W(CW), .ADDR_W(AW)) i_tmr_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .ch_event(ch_event), .ch_cap_we(ch_cap_we),
    .ch_cap_val(ch_cap_val), .ch_count(ch_count), .ch_ctl(ch_ctl),
    .ch_load(ch_load), .ch_load_rd(ch_load_rd), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] widen(input logic [CW-1:0] v);
    logic [31:0] r = 0;
    for (int i = 0; i < CW; i++) r[i] = v[i];
    return r;
  endfunction

  task automatic model_step();
    int ch = bus_addr[4];
    int s = bus_addr[3:2];
    logic [10:0] nc [2];
    logic [CW-1:0] nl [2];
    logic clr;
    m_ack = bus_wr | bus_rd;
    m_rdata = 0;
    m_lrd = 0;
    if (bus_rd) begin
      if (s == 0) m_rdata = {21'd0, m_enall, m_ctl[ch][9:0]};
      else if (s == 1) begin m_rdata = widen(m_load[ch]); m_lrd[ch] = 1; end
      else if (s == 2) m_rdata = widen(ch_count[ch]);
    end
    for (int c = 0; c < 2; c++) begin
      nc[c] = m_ctl[c];
      nl[c] = m_load[c];
      clr = 0;
      if (bus_wr && s == 0 && ch == c) begin
        if (bus_be[0]) nc[c][7:0] = bus_wdata[7:0];
        if (bus_be[1]) begin nc[c][9] = bus_wdata[9]; clr = bus_wdata[8]; end
      end
      if (ch_event[c]) nc[c][8] = 1;
      else if (clr) nc[c][8] = 0;
      if (ch_cap_we[c]) nl[c] = ch_cap_val[c];
      else if (bus_wr && s == 1 && ch == c)
        for (int i = 0; i < CW; i++) if (bus_be[i/8]) nl[c][i] = bus_wdata[i];
    end
    if (bus_wr && s == 0 && bus_be[1]) begin
      m_enall = bus_wdata[10];
      if (bus_wdata[10]) begin nc[0][7] = 1; nc[1][7] = 1; end
    end
    for (int c = 0; c < 2; c++) begin m_ctl[c] = nc[c]; m_load[c] = nl[c]; end
  endtask

  task automatic compare();
    for (int c = 0; c < 2; c++) begin
      chk("R2 ctl", {21'd0, ch_ctl[c]}, {21'd0, m_enall, m_ctl[c][9:0]});
      chk("R8 load", widen(ch_load[c]), widen(m_load[c]));
    end
    chk("R7 irq", {31'd0, irq},
        {31'd0, (m_ctl[0][8] & m_ctl[0][6]) | (m_ctl[1][8] & m_ctl[1][6])});
    chk("R9 ack", {31'd0, bus_ack}, {31'd0, m_ack});
    chk("R1 rdata", bus_rdata, m_rdata);
    chk("R10 load_rd", {30'd0, ch_load_rd}, {30'd0, m_lrd});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    bus_wr = 0; bus_rd = 0; ch_event = 0; ch_cap_we = 0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1;
    tick();
  endtask

  task automatic rd(input logic [4:0] a);
    bus_addr = a; bus_rd = 1;
    tick();
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin m_ctl[c] = 0; m_load[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset state
    compare();
    chk("R2 reset ctl0", {21'd0, ch_ctl[0]}, 0);
    ch_count[0] = 12'h9A5; ch_count[1] = 12'h3C1;
    // R2: lane-0 fields written, read back
    wr(5'h00, 32'h0000_003F, 4'b0001);
    rd(5'h00);
    chk("R2 ctl0 readback", bus_rdata, 32'h0000_003F);
    // R8: right-justified load with truncation, masked lane write
    wr(5'h04, 32'hFFFA_BCDE, 4'b1111);
    chk("R8 load truncation", widen(ch_load[0]), 32'h0000_0CDE);
    wr(5'h04, 32'h0000_0500, 4'b0010);
    chk("R8 lane mask", widen(ch_load[0]), 32'h0000_05DE);
    rd(5'h04);
    chk("R10 load read pulse", {30'd0, ch_load_rd}, 32'h1);
    // R1: counts, read-only, unmapped
    rd(5'h18);
    chk("R1 count1", bus_rdata, 32'h0000_03C1);
    wr(5'h08, 32'hFFFF_FFFF, 4'b1111);
    rd(5'h08);
    chk("R1 count0 unchanged", bus_rdata, 32'h0000_09A5);
    rd(5'h0C);
    chk("R1 unmapped 0C", bus_rdata, 0);
    rd(5'h1C);
    chk("R1 unmapped 1C", bus_rdata, 0);
    // R3: enable-all from ctl1 starts both
    wr(5'h10, 32'h0000_0400, 4'b0010);
    chk("R3 ten0", {31'd0, ch_ctl[0][7]}, 1);
    chk("R3 ten1", {31'd0, ch_ctl[1][7]}, 1);
    // R4: writing zero clears enable-all only
    wr(5'h00, 32'h0000_0000, 4'b0010);
    chk("R4 enall cleared", {31'd0, ch_ctl[0][10]}, 0);
    chk("R4 ten kept", {31'd0, ch_ctl[1][7]}, 1);
    // R3 set wins over lane-0 write of timer enable 0
    wr(5'h00, 32'h0000_0400, 4'b0011);
    chk("R3 set over zero", {31'd0, ch_ctl[0][7]}, 1);
    // R5/R7: event sets flag, irq gated
    ch_event[1] = 1; tick();
    chk("R5 flag set", {31'd0, ch_ctl[1][8]}, 1);
    chk("R7 gated", {31'd0, irq}, 0);
    wr(5'h10, 32'h0000_00C0, 4'b0001);
    chk("R7 enabled irq", {31'd0, irq}, 1);
    wr(5'h10, 32'h0000_0000, 4'b0010);
    chk("R5 write0 no effect", {31'd0, ch_ctl[1][8]}, 1);
    // R6: event coincides with clear
    ch_event[1] = 1;
    wr(5'h10, 32'h0000_0100, 4'b0010);
    chk("R6 event wins", {31'd0, ch_ctl[1][8]}, 1);
    wr(5'h10, 32'h0000_0100, 4'b0010);
    chk("R5 cleared", {31'd0, ch_ctl[1][8]}, 0);
    chk("R7 irq dropped", {31'd0, irq}, 0);
    // R7: OR of channels, channel 0 enabled
    wr(5'h00, 32'h0000_0040, 4'b0001);
    ch_event = 2'b11; tick();
    chk("R7 or", {31'd0, irq}, 1);
    wr(5'h00, 32'h0000_0100, 4'b0010);
    chk("R7 other channel", {31'd0, irq}, 1);
    // R11: capture beats bus write
    ch_cap_we[0] = 1; ch_cap_val[0] = 12'h123;
    wr(5'h04, 32'h0000_0FFF, 4'b1111);
    chk("R11 capture wins", widen(ch_load[0]), 32'h0000_0123);
    ch_cap_we[1] = 1; ch_cap_val[1] = 12'hABC; tick();
    rd(5'h14);
    chk("R11 captured read", bus_rdata, 32'h0000_0ABC);
    // R1: upper address bit beyond map is not decoded when ADDR_W=5
    repeat (3) tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule